// File: doc/BRIEF.md
# Retirement-Time Instruction Checker

This block sits behind a speculative out-of-order core and validates, one at a time and in program order, every instruction record the core retires. Each record carries the core's PC, the instruction word, both source operand values, the result (or the effective address for memory operations) and the predicted next PC. The checker holds its own PC, its own eight-entry register file, a program memory and a data memory. It fetches at its own PC and re-executes the instruction from its own state. It does not accept any field from the core until that field has been compared against its own value.

When all five comparisons agree, the record commits in the next cycle. When any comparison disagrees, the checker stalls the core's stream for one cycle and evaluates the held record a second time, using only its own state. The result of that evaluation decides the outcome:

- If the second evaluation agrees with the core, the first disagreement was an upset inside the checker. The core's values commit and the event is counted as a checker transient.
- If the second evaluation still disagrees, the core is at fault. The checker's own values commit, the core is flushed, and the core is redirected to the corrected next PC.

The small integer instruction set has eight 16-bit registers and a fixed 16-bit encoding:

- opcode in [15:13]: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 load, 5 store, 6 branch-if-equal, 7 add-immediate
- destination in [12:10]
- first source in [9:7]
- second source in [6:4]
- signed 4-bit immediate in [3:0]

Top module: `chk_retire_top`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `cm_valid` and `flush` are 0, both event counters are 0, every register holds 0, and the first committed PC is `RESET_PC` (0).
- R2: A record accepted on a clock edge (`in_valid` and `in_ready` both high) whose five checks all agree produces `cm_valid`=1 with `cm_kind`=0 (clean) and `flush`=0 right after that edge. Records commit strictly in the order they are accepted.
- R3: The core's PC is compared with the checker's own PC. On a difference the checker commits its own values and redirects the core.
- R4: The core's instruction word is compared with the checker's fetch from program memory at the checker's PC.
- R5: The core's two operand values are compared with the checker's register file entries named by the fetched instruction's source fields.
- R6: The core's result field is compared with the recomputed value. That value is the ALU result for ADD/SUB/AND/OR and add-immediate, the address rs1+imm for load and store, and the taken flag (0 or 1) for branch-if-equal.
- R7: The core's next PC is compared with the computed one. That is PC+1, or PC+1+imm for a branch-if-equal whose two operands are equal.
- R8: On a first-pass disagreement, `in_ready` is 0 for exactly one cycle and the record commits one cycle later than a clean record. If the second evaluation still disagrees, the checker commits its own result, pulses `flush` together with `cm_kind`=2, and presents the computed next PC on `redirect_pc`. The recovery state is held in three voted copies.
- R9: A first-pass disagreement caused by an upset (modelled by `in_flip`, which inverts bit 0 of the first-pass recomputed result only) with a correct core commits the core's values with `cm_kind`=1 and no flush.
- R10: Transient and core-fault events are counted in two separate counters of `CNT_W` bits that saturate at their maximum value.
- R11: A committed ALU or add-immediate instruction writes its value to the destination register. A committed store writes data memory at the low address bits. A committed load writes the destination register with data memory at that address. All of these are shown on the `cm_*` ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | $clog2(IMEM_DEPTH) | Program memory write address |
| prog_data | input | 16 | Program memory write data |
| in_valid | input | 1 | Core presents a retiring record |
| in_ready | output | 1 | Checker can accept a record |
| in_pc | input | 16 | Core's PC of the record |
| in_ins | input | 16 | Core's instruction word |
| in_opa | input | 16 | Core's first operand value |
| in_opb | input | 16 | Core's second operand value |
| in_res | input | 16 | Core's result or address |
| in_npc | input | 16 | Core's next PC |
| in_flip | input | 1 | Upset model: inverts bit 0 of the first-pass recomputed result |
| cm_valid | output | 1 | One instruction committed |
| cm_kind | output | 2 | 0 clean, 1 checker transient, 2 core fault |
| cm_pc | output | 16 | PC of the committed instruction |
| cm_rd_we | output | 1 | Commit writes a register |
| cm_rd | output | 3 | Register written |
| cm_rd_data | output | 16 | Value written to the register |
| cm_st_we | output | 1 | Commit writes data memory |
| cm_st_addr | output | 16 | Store address |
| cm_st_data | output | 16 | Store data |
| flush | output | 1 | Flush the core |
| redirect_pc | output | 16 | PC at which the core restarts |
| cnt_transient | output | CNT_W | Saturating count of checker transients |
| cnt_corefault | output | CNT_W | Saturating count of core faults |

## Verification
A clean record's commit outputs are due in the cycle after the edge that accepts it. A mismatching record is due one cycle later: `in_ready` is low in between, and `flush`, `redirect_pc` and both counters update on that same later edge. The bench drives each record just after a falling edge and samples at the next falling edge. Its reference model decides in advance whether the record takes the one-cycle or the two-cycle path. It then checks the stall cycle, or the absence of one, together with every commit field at exactly that sample point.

// File: rtl/chk_pkg.sv
package chk_pkg;

  localparam int XLEN = 16;
  localparam int RIDX = 3;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_LD   = 3'd4;
  localparam logic [2:0] OP_ST   = 3'd5;
  localparam logic [2:0] OP_BEQ  = 3'd6;
  localparam logic [2:0] OP_ADDI = 3'd7;

  localparam logic [1:0] ST_CHECK = 2'b00;
  localparam logic [1:0] ST_THIRD = 2'b01;

  localparam logic [1:0] K_CLEAN     = 2'd0;
  localparam logic [1:0] K_TRANSIENT = 2'd1;
  localparam logic [1:0] K_COREFAULT = 2'd2;

  localparam int NCHK = 5;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] ins;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] npc;
  } rec_t;

  function automatic logic [XLEN-1:0] sext4(input logic [3:0] v);
    return {{(XLEN-4){v[3]}}, v};
  endfunction

endpackage

// File: rtl/chk_exec.sv
module chk_exec
  import chk_pkg::*;
(
  input  rec_t            rec,
  input  logic [XLEN-1:0] cpc,
  input  logic [XLEN-1:0] cins,
  input  logic [XLEN-1:0] va,
  input  logic [XLEN-1:0] vb,
  input  logic            flip,
  output logic [RIDX-1:0] ra,
  output logic [RIDX-1:0] rb,
  output logic [XLEN-1:0] xres,
  output logic [XLEN-1:0] xnpc,
  output logic [NCHK-1:0] miss
);
  logic [2:0]      op;
  logic [XLEN-1:0] imm;
  logic [XLEN-1:0] res_cmp;
  logic            eq;

  assign op  = cins[15:13];
  assign ra  = cins[9:7];
  assign rb  = cins[6:4];
  assign imm = sext4(cins[3:0]);
  assign eq  = (va == vb);

  always_comb begin
    case (op)
      OP_ADD:  xres = va + vb;
      OP_SUB:  xres = va - vb;
      OP_AND:  xres = va & vb;
      OP_OR:   xres = va | vb;
      OP_LD,
      OP_ST:   xres = va + imm;
      OP_BEQ:  xres = {{(XLEN-1){1'b0}}, eq};
      default: xres = va + imm;
    endcase
  end

  assign xnpc = (op == OP_BEQ && eq) ? cpc + 16'd1 + imm : cpc + 16'd1;

  // upset model touches only the first-pass comparison copy
  assign res_cmp = xres ^ {{(XLEN-1){1'b0}}, flip};

  assign miss[0] = (rec.pc != cpc);
  assign miss[1] = (rec.ins != cins);
  assign miss[2] = (rec.opa != va) || (rec.opb != vb);
  assign miss[3] = (rec.res != res_cmp);
  assign miss[4] = (rec.npc != xnpc);

endmodule

// File: rtl/chk_tmr_reg.sv
module chk_tmr_reg #(
  parameter int         W    = 2,
  parameter logic [W-1:0] INIT = '0
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] cp [3];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (rst) cp[i] <= INIT;
      else     cp[i] <= d;
    end
  end

  assign q = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);

  // R8: the three copies of the recovery state never diverge
  p_copies_agree_r8: assert property (@(posedge clk) disable iff (rst)
    (cp[0] == cp[1]) && (cp[1] == cp[2]));

endmodule

// File: rtl/chk_sat_ctr.sv
module chk_sat_ctr #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                    q <= '0;
    else if (inc && q != MAXV)  q <= q + 1'b1;
  end

  p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (q == MAXV) |=> (q == MAXV));

  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    (inc && q != MAXV) |=> (q == $past(q) + 1'b1));

endmodule

// File: rtl/chk_retire_top.sv
module chk_retire_top
  import chk_pkg::*;
#(
  parameter int        IMEM_DEPTH = 32,
  parameter int        DMEM_DEPTH = 16,
  parameter int        CNT_W      = 16,
  parameter logic [15:0] RESET_PC = 16'd0
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          prog_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr,
  input  logic [15:0]                   prog_data,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [15:0]                   in_pc,
  input  logic [15:0]                   in_ins,
  input  logic [15:0]                   in_opa,
  input  logic [15:0]                   in_opb,
  input  logic [15:0]                   in_res,
  input  logic [15:0]                   in_npc,
  input  logic                          in_flip,
  output logic                          cm_valid,
  output logic [1:0]                    cm_kind,
  output logic [15:0]                   cm_pc,
  output logic                          cm_rd_we,
  output logic [2:0]                    cm_rd,
  output logic [15:0]                   cm_rd_data,
  output logic                          cm_st_we,
  output logic [15:0]                   cm_st_addr,
  output logic [15:0]                   cm_st_data,
  output logic                          flush,
  output logic [15:0]                   redirect_pc,
  output logic [CNT_W-1:0]              cnt_transient,
  output logic [CNT_W-1:0]              cnt_corefault
);
  localparam int IA_W = $clog2(IMEM_DEPTH);
  localparam int DA_W = $clog2(DMEM_DEPTH);
  localparam int NREG = 1 << RIDX;

  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [XLEN-1:0] rf   [NREG];

  logic [1:0]      st_d, st_q;
  logic [XLEN-1:0] pc_q;
  rec_t            rec_in, rec_q, rec_use;

  logic            in_check, third, accept, clean, do_commit, use_core;
  logic [XLEN-1:0] cins, va, vb, xres, xnpc;
  logic [RIDX-1:0] ra, rb, rd;
  logic [NCHK-1:0] miss;
  logic [2:0]      op;
  logic            wr_rd, is_st;
  logic [XLEN-1:0] c_res, c_opb, c_npc, ld_data, rd_data;

  // ---------------- control state, three voted copies ----------------
  chk_tmr_reg #(.W(2), .INIT(ST_CHECK)) u_state (
    .clk (clk), .rst (rst), .d (st_d), .q (st_q)
  );

  assign in_check = (st_q == ST_CHECK);
  assign third    = (st_q == ST_THIRD);
  assign in_ready = in_check;
  assign accept   = in_valid && in_check;

  assign rec_in  = {in_pc, in_ins, in_opa, in_opb, in_res, in_npc};
  assign rec_use = third ? rec_q : rec_in;

  // ---------------- fetch, register read, re-execute ----------------
  assign cins = imem[pc_q[IA_W-1:0]];
  assign va   = rf[ra];
  assign vb   = rf[rb];

  chk_exec u_exec (
    .rec  (rec_use),
    .cpc  (pc_q),
    .cins (cins),
    .va   (va),
    .vb   (vb),
    .flip (in_flip && in_check),
    .ra   (ra),
    .rb   (rb),
    .xres (xres),
    .xnpc (xnpc),
    .miss (miss)
  );

  assign clean = (miss == '0);

  always_comb begin
    st_d = ST_CHECK;
    if (accept && !clean) st_d = ST_THIRD;
  end

  // ---------------- commit selection ----------------
  assign do_commit = (accept && clean) || third;
  assign use_core  = clean;
  assign op        = cins[15:13];
  assign rd        = cins[12:10];
  assign wr_rd     = (op != OP_ST) && (op != OP_BEQ);
  assign is_st     = (op == OP_ST);

  assign c_res   = use_core ? rec_use.res : xres;
  assign c_opb   = use_core ? rec_use.opb : vb;
  assign c_npc   = use_core ? rec_use.npc : xnpc;
  assign ld_data = dmem[c_res[DA_W-1:0]];
  assign rd_data = (op == OP_LD) ? ld_data : c_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= RESET_PC;
      rec_q       <= '0;
      cm_valid    <= 1'b0;
      cm_kind     <= K_CLEAN;
      cm_pc       <= '0;
      cm_rd_we    <= 1'b0;
      cm_rd       <= '0;
      cm_rd_data  <= '0;
      cm_st_we    <= 1'b0;
      cm_st_addr  <= '0;
      cm_st_data  <= '0;
      flush       <= 1'b0;
      redirect_pc <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      cm_valid   <= do_commit;
      cm_kind    <= !third ? K_CLEAN : (clean ? K_TRANSIENT : K_COREFAULT);
      cm_pc      <= pc_q;
      cm_rd_we   <= do_commit && wr_rd;
      cm_rd      <= rd;
      cm_rd_data <= rd_data;
      cm_st_we   <= do_commit && is_st;
      cm_st_addr <= c_res;
      cm_st_data <= c_opb;
      flush      <= third && !clean;
      if (third && !clean) redirect_pc <= xnpc;
      if (accept) rec_q <= rec_in;
      if (do_commit) begin
        pc_q <= c_npc;
        if (wr_rd) rf[rd] <= rd_data;
      end
    end
  end

  // memories without reset, one write port each
  always_ff @(posedge clk) begin
    if (do_commit && is_st) dmem[c_res[DA_W-1:0]] <= c_opb;
  end

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  // ---------------- event counters ----------------
  chk_sat_ctr #(.W(CNT_W)) u_cnt_tr (
    .clk (clk), .rst (rst), .inc (third && clean), .q (cnt_transient)
  );

  chk_sat_ctr #(.W(CNT_W)) u_cnt_cf (
    .clk (clk), .rst (rst), .inc (third && !clean), .q (cnt_corefault)
  );

  // ---------------- assertions ----------------
  p_clean_commits_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && clean) |=> (cm_valid && cm_kind == K_CLEAN && !flush));

  p_mismatch_stalls_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && !clean) |=> (!in_ready && !cm_valid));

  p_flush_with_commit_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> (cm_valid && cm_kind == K_COREFAULT));

  p_transient_no_flush_r9: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && cm_kind == K_TRANSIENT) |-> !flush);

endmodule

// File: tb/chk_retire_top_tb.sv
`timescale 1ns/1ps
module chk_retire_top_tb;
  localparam int IMEM_DEPTH = 32;
  localparam int DMEM_DEPTH = 16;
  localparam int CNT_W      = 4;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, prog_we, in_valid, in_ready, in_flip;
  logic [4:0]  prog_addr;
  logic [15:0] prog_data, in_pc, in_ins, in_opa, in_opb, in_res, in_npc;
  logic        cm_valid, cm_rd_we, cm_st_we, flush;
  logic [1:0]  cm_kind;
  logic [2:0]  cm_rd;
  logic [15:0] cm_pc, cm_rd_data, cm_st_addr, cm_st_data, redirect_pc;
  logic [CNT_W-1:0] cnt_transient, cnt_corefault;

  chk_retire_top #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH),
                   .CNT_W(CNT_W), .RESET_PC(16'd0)) u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_ins(in_ins), .in_opa(in_opa), .in_opb(in_opb),
    .in_res(in_res), .in_npc(in_npc), .in_flip(in_flip),
    .cm_valid(cm_valid), .cm_kind(cm_kind), .cm_pc(cm_pc),
    .cm_rd_we(cm_rd_we), .cm_rd(cm_rd), .cm_rd_data(cm_rd_data),
    .cm_st_we(cm_st_we), .cm_st_addr(cm_st_addr), .cm_st_data(cm_st_data),
    .flush(flush), .redirect_pc(redirect_pc),
    .cnt_transient(cnt_transient), .cnt_corefault(cnt_corefault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] m_rf [8];
  logic [15:0] m_dm [16];
  logic [15:0] m_im [32];
  logic [15:0] m_pc;
  int          m_tr, m_cf;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int op, int rd, int rs1, int rs2, int imm);
    logic [31:0] o = op, d = rd, a = rs1, b = rs2, m = imm;
    return {o[2:0], d[2:0], a[2:0], b[2:0], m[3:0]};
  endfunction

  // behavioural re-execution of the instruction at the model PC
  task automatic model_eval(output logic [15:0] ti, ta, tb, tr, tn);
    logic [15:0] imm;
    ti  = m_im[m_pc[4:0]];
    ta  = m_rf[ti[9:7]];
    tb  = m_rf[ti[6:4]];
    imm = {{12{ti[3]}}, ti[3:0]};
    tn  = m_pc + 16'd1;
    case (ti[15:13])
      3'd0: tr = ta + tb;
      3'd1: tr = ta - tb;
      3'd2: tr = ta & tb;
      3'd3: tr = ta | tb;
      3'd6: begin
        tr = (ta == tb) ? 16'd1 : 16'd0;
        if (ta == tb) tn = m_pc + 16'd1 + imm;
      end
      default: tr = ta + imm;
    endcase
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 idle cm_valid", {15'd0, cm_valid}, 16'd0);
      chk("R8 idle flush", {15'd0, flush}, 16'd0);
    end
  endtask

  task automatic send(string req, logic [15:0] pc, logic [15:0] ins,
                      logic [15:0] a, logic [15:0] b, logic [15:0] r,
                      logic [15:0] npc, logic flip);
    logic [15:0] ti, ta, tb, tr, tn, cres, copb, cnpc, rdd;
    logic [2:0]  op;
    bit cmiss, fmiss;
    model_eval(ti, ta, tb, tr, tn);
    cmiss = (pc !== m_pc) || (ins !== ti) || (a !== ta) || (b !== tb) ||
            (r !== tr) || (npc !== tn);
    fmiss = cmiss || flip;
    @(negedge clk);
    chk({req, " ready before"}, {15'd0, in_ready}, 16'd1);
    in_valid = 1'b1; in_pc = pc; in_ins = ins; in_opa = a; in_opb = b;
    in_res = r; in_npc = npc; in_flip = flip;
    @(negedge clk);
    in_valid = 1'b0; in_flip = 1'b0;
    if (fmiss) begin
      chk({req, " R8 stall ready"}, {15'd0, in_ready}, 16'd0);
      chk({req, " R8 stall no commit"}, {15'd0, cm_valid}, 16'd0);
      @(negedge clk);
    end
    cres = cmiss ? tr : r;
    copb = cmiss ? tb : b;
    cnpc = cmiss ? tn : npc;
    op   = ti[15:13];
    rdd  = (op == 3'd4) ? m_dm[cres[3:0]] : cres;
    if (fmiss && cmiss && m_cf < CMAX) m_cf++;
    if (fmiss && !cmiss && m_tr < CMAX) m_tr++;
    chk({req, " cm_valid"}, {15'd0, cm_valid}, 16'd1);
    chk({req, " cm_kind"}, {14'd0, cm_kind}, !fmiss ? 16'd0 : (cmiss ? 16'd2 : 16'd1));
    chk({req, " flush"}, {15'd0, flush}, {15'd0, fmiss && cmiss});
    if (fmiss && cmiss) chk({req, " R8 redirect"}, redirect_pc, tn);
    chk({req, " cm_pc"}, cm_pc, m_pc);
    chk({req, " R11 rd_we"}, {15'd0, cm_rd_we}, {15'd0, op != 3'd5 && op != 3'd6});
    if (op != 3'd5 && op != 3'd6) begin
      chk({req, " R11 rd"}, {13'd0, cm_rd}, {13'd0, ti[12:10]});
      chk({req, " R11 rd_data"}, cm_rd_data, rdd);
      m_rf[ti[12:10]] = rdd;
    end
    chk({req, " R11 st_we"}, {15'd0, cm_st_we}, {15'd0, op == 3'd5});
    if (op == 3'd5) begin
      chk({req, " R11 st_addr"}, cm_st_addr, cres);
      chk({req, " R11 st_data"}, cm_st_data, copb);
      m_dm[cres[3:0]] = copb;
    end
    chk({req, " R10 cnt_transient"}, {12'd0, cnt_transient}, 16'(m_tr));
    chk({req, " R10 cnt_corefault"}, {12'd0, cnt_corefault}, 16'(m_cf));
    chk({req, " ready after"}, {15'd0, in_ready}, 16'd1);
    m_pc = cnpc;
  endtask

  task automatic good(string req, logic flip);
    logic [15:0] ti, ta, tb, tr, tn;
    model_eval(ti, ta, tb, tr, tn);
    send(req, m_pc, ti, ta, tb, tr, tn, flip);
  endtask

  task automatic bad_res(string req, logic flip);
    logic [15:0] ti, ta, tb, tr, tn;
    model_eval(ti, ta, tb, tr, tn);
    send(req, m_pc, ti, ta, tb, tr ^ 16'h0100, tn, flip);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] ti, ta, tb, tr, tn;
    rst = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    in_valid = 1'b0; in_flip = 1'b0; in_pc = '0; in_ins = '0;
    in_opa = '0; in_opb = '0; in_res = '0; in_npc = '0;
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    for (int i = 0; i < 16; i++) m_dm[i] = '0;
    m_pc = 16'd0; m_tr = 0; m_cf = 0;

    m_im[0]  = enc(7, 1, 0, 0, 5);
    m_im[1]  = enc(7, 2, 0, 0, -3);
    m_im[2]  = enc(0, 3, 1, 2, 0);
    m_im[3]  = enc(1, 4, 1, 2, 0);
    m_im[4]  = enc(2, 5, 1, 2, 0);
    m_im[5]  = enc(3, 6, 3, 4, 0);
    m_im[6]  = enc(5, 0, 1, 6, 1);
    m_im[7]  = enc(4, 7, 1, 0, 1);
    m_im[8]  = enc(6, 0, 3, 3, 2);
    for (int i = 9; i < 31; i++) m_im[i] = enc(7, 1, 1, 0, 1);
    m_im[11] = enc(6, 0, 1, 2, 3);
    m_im[31] = enc(6, 0, 0, 0, -8);

    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 5'(i); prog_data = m_im[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 ready", {15'd0, in_ready}, 16'd1);
    chk("R1 cm_valid", {15'd0, cm_valid}, 16'd0);
    chk("R1 flush", {15'd0, flush}, 16'd0);
    chk("R1 cnt_transient", {12'd0, cnt_transient}, 16'd0);
    chk("R1 cnt_corefault", {12'd0, cnt_corefault}, 16'd0);
    idle(2);

    // R2 / R11: clean stream with ALU, store, load and taken branch
    good("R1 first commit", 1'b0);
    good("R2 addi neg", 1'b0);
    good("R2 add", 1'b0);
    good("R2 sub", 1'b0);
    good("R2 and", 1'b0);
    good("R2 or", 1'b0);
    good("R11 store", 1'b0);
    good("R11 load", 1'b0);
    good("R7 taken branch", 1'b0);
    chk("R7 branch target", m_pc, 16'd11);

    // R7: wrong next PC on a not-taken branch
    model_eval(ti, ta, tb, tr, tn);
    send("R7 npc", m_pc, ti, ta, tb, tr, tn + 16'd3, 1'b0);
    // R3: wrong PC
    model_eval(ti, ta, tb, tr, tn);
    send("R3 pc", m_pc + 16'd4, ti, ta, tb, tr, tn, 1'b0);
    // R4: wrong instruction word
    model_eval(ti, ta, tb, tr, tn);
    send("R4 ins", m_pc, ti ^ 16'h0001, ta, tb, tr, tn, 1'b0);
    // R5: wrong operand
    model_eval(ti, ta, tb, tr, tn);
    send("R5 opa", m_pc, ti, ta + 16'd1, tb, tr, tn, 1'b0);
    // R6: wrong result
    bad_res("R6 res", 1'b0);
    idle(1);
    // R9: checker upset with a correct core
    good("R9 transient", 1'b1);
    // R8: upset and core error together remain a core fault
    bad_res("R8 flip plus core error", 1'b1);
    good("R2 after recovery", 1'b0);

    // R10: drive both counters into saturation
    for (int i = 0; i < 14; i++) bad_res("R10 core fault", 1'b0);
    for (int i = 0; i < 17; i++) good("R10 transient", 1'b1);
    for (int i = 0; i < 10; i++) good("R2 loop", 1'b0);
    idle(2);

    done = 1;
    summary();
    $finish;
  end

endmodule